// File: doc/BRIEF.md
# Supply Fault Protection Sequencer

This block is the digital controller on the secondary side of a three-rail supply. External comparators send it one overvoltage flag and one undervoltage flag per rail. The system sends it an active-low on/off request. The block drives `rails_off`, and a high level on that output keeps the main rails switched off. The block has four jobs:
- It filters the on/off request so that only a request held steady through the debounce window has any effect.
- After every turn-on it ignores undervoltage for a fixed blanking window, so the rails have time to ramp.
- It counts a rail fault only when the flag lasts longer than a short glitch filter, and then it latches the fault.
- At turn-off it keeps the rails on for a short extra delay before it drops them.

Every time window is a parameter counted in clock cycles. The defaults assume a 1 MHz clock: 38 ms debounce, 75 ms blanking, 73 µs fault filter and 2.3 ms turn-off delay. The block exports the latched fault state as `fault_active` so that a separate power-good generator can use it.

Top module: `supply_fault_seq`

## Requirements
- R1: During reset and on the first cycle after it, `rails_off` is 1 and `fault_active` is 0. The request is treated as "off" until it has passed debounce.
- R2: While the debounced request is high, `rails_off` stays 1. When `onoff_req_n` goes low and stays low, `rails_off` falls exactly DEB_CYC+3 cycles after the input change: two synchroniser stages, DEB_CYC debounce cycles and one sequencer register.
- R3: A level change on `onoff_req_n` that lasts fewer than DEB_CYC cycles has no effect on `rails_off`. This holds for both directions of the change.
- R4: For BLANK_CYC cycles after each turn-on, undervoltage flags are masked. If an undervoltage flag is held from the start of the blanking window, the fault is seen BLANK_CYC+FILT_CYC+1 cycles after `rails_off` fell.
- R5: Overvoltage is never blanked. An overvoltage flag that appears during the blanking window latches a fault, and both `rails_off` and `fault_active` are 1 exactly FILT_CYC+3 cycles after the flag rises at the input.
- R6: A fault needs the combined fault condition to be active for FILT_CYC consecutive cycles. The combined condition is the OR of all overvoltage flags with the unmasked undervoltage flags. A single inactive cycle restarts the count from zero, so pulses shorter than FILT_CYC cycles are ignored.
- R7: A latched fault holds `rails_off` and `fault_active` at 1 even while the request stays low. Only a low-to-high transition of the debounced request clears it, and `fault_active` falls DEB_CYC+3 cycles after `onoff_req_n` rises. While `rails_off` is 0, `fault_active` is 0.
- R8: At turn-off, `rails_off` rises exactly DEB_CYC+3+OFFDLY_CYC cycles after `onoff_req_n` rises. It stays 0 during the extra OFFDLY_CYC cycles.
- R9: Faults that arrive while the debounced request is high are ignored and leave `fault_active` at 0. This covers both the off state and the turn-off delay.
- R10: Each rail is monitored separately. A qualified flag on any bit position of `ov_flag` or `uv_flag` trips the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| onoff_req_n | input | 1 | Asynchronous on/off request; low asks for rails on |
| ov_flag | input | NRAILS | Asynchronous per-rail overvoltage flags, 1 = over limit |
| uv_flag | input | NRAILS | Asynchronous per-rail undervoltage flags, 1 = under limit |
| rails_off | output | 1 | Registered fault-protection output; 1 = main rails off |
| fault_active | output | 1 | Latched fault indication for the power-good generator |

## Verification
The bench builds the block with DEB_CYC=8, BLANK_CYC=20, FILT_CYC=4 and OFFDLY_CYC=5, keeping NRAILS=3. With these values every path can be reached within a few hundred cycles, and each latency can be checked at the exact cycle the requirements give. The paths are: debounce rejection in both directions, the end of blanking, the filter restart after a one-cycle gap, the latch clear and the turn-off delay. The small counts also make each off-by-one boundary visible, one cycle before and at the expected edge.

// File: rtl/sfs_pkg.sv
`timescale 1ns/1ps
package sfs_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF   = 2'd0,
    SEQ_BLANK = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_STOP  = 2'd3
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sfs_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser for a vector of asynchronous level inputs.
module sfs_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/sfs_debounce.sv
`timescale 1ns/1ps
// Level debouncer: the output follows the input only after the input
// has differed from it for CYC consecutive cycles.
module sfs_debounce #(
  parameter int   CYC  = 38000,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int            CW   = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dout  <= INIT;
    end else if (din == dout) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      dout  <= din;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  db_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/sfs_fault_filter.sv
`timescale 1ns/1ps
// Per-rail fault combine with undervoltage masking and a persistence
// filter: hit rises after the combined condition holds for CYC cycles.
module sfs_fault_filter #(
  parameter int NR  = 3,
  parameter int CYC = 73
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          uv_en,
  input  logic [NR-1:0] ov,
  input  logic [NR-1:0] uv,
  output logic          hit
);

  localparam int            CW   = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [NR-1:0] rail_bad;
  logic          cond;
  logic [CW-1:0] cnt_q;

  for (genvar i = 0; i < NR; i++) begin : g_rail
    assign rail_bad[i] = ov[i] | (uv_en & uv[i]);
  end

  assign cond = arm & (|rail_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hit   <= 1'b0;
    end else if (!cond) begin
      cnt_q <= '0;
      hit   <= 1'b0;
    end else if (cnt_q == LAST) begin
      hit   <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      hit   <= 1'b0;
    end
  end

  // R6
  filt_cause_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(cond));

  // R6
  filt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !cond |=> (!hit && cnt_q == '0));

endmodule

// File: rtl/supply_fault_seq.sv
`timescale 1ns/1ps
// Secondary-side supply fault protection sequencer.
module supply_fault_seq #(
  parameter int NRAILS     = 3,
  parameter int DEB_CYC    = 38000,
  parameter int BLANK_CYC  = 75000,
  parameter int FILT_CYC   = 73,
  parameter int OFFDLY_CYC = 2300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              onoff_req_n,
  input  logic [NRAILS-1:0] ov_flag,
  input  logic [NRAILS-1:0] uv_flag,
  output logic              rails_off,
  output logic              fault_active
);

  import sfs_pkg::*;

  localparam int            TW        = $clog2(max_of(BLANK_CYC, OFFDLY_CYC) + 1);
  localparam logic [TW-1:0] BLANK_END = TW'(BLANK_CYC - 1);
  localparam logic [TW-1:0] STOP_END  = TW'(OFFDLY_CYC - 1);

  logic                req_s;
  logic                req_db;
  logic                req_db_d;
  logic [2*NRAILS-1:0] flags_s;
  logic [NRAILS-1:0]   ov_s;
  logic [NRAILS-1:0]   uv_s;
  logic                arm;
  logic                uv_en;
  logic                hit;

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          latch_q, latch_d;
  logic          req_rise;

  sfs_sync #(.W(1), .RST_VAL(1'b1)) u_req_sync (
    .clk(clk), .rst(rst), .d(onoff_req_n), .q(req_s)
  );

  sfs_sync #(.W(2*NRAILS), .RST_VAL('0)) u_flag_sync (
    .clk(clk), .rst(rst), .d({ov_flag, uv_flag}), .q(flags_s)
  );

  assign ov_s = flags_s[2*NRAILS-1:NRAILS];
  assign uv_s = flags_s[NRAILS-1:0];

  sfs_debounce #(.CYC(DEB_CYC), .INIT(1'b1)) u_req_db (
    .clk(clk), .rst(rst), .din(req_s), .dout(req_db)
  );

  assign arm   = ((state_q == SEQ_BLANK) || (state_q == SEQ_RUN)) && !req_db;
  assign uv_en = (state_q == SEQ_RUN);

  sfs_fault_filter #(.NR(NRAILS), .CYC(FILT_CYC)) u_filter (
    .clk(clk), .rst(rst), .arm(arm), .uv_en(uv_en),
    .ov(ov_s), .uv(uv_s), .hit(hit)
  );

  assign req_rise = req_db & ~req_db_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    latch_d = latch_q;
    if (req_rise) latch_d = 1'b0;
    case (state_q)
      SEQ_OFF: begin
        if (!req_db && !latch_q) begin
          state_d = SEQ_BLANK;
          tmr_d   = '0;
        end
      end
      SEQ_BLANK: begin
        if (req_db) begin
          state_d = SEQ_STOP;
          tmr_d   = '0;
        end else if (hit) begin
          state_d = SEQ_OFF;
          latch_d = 1'b1;
        end else if (tmr_q == BLANK_END) begin
          state_d = SEQ_RUN;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      SEQ_RUN: begin
        if (req_db) begin
          state_d = SEQ_STOP;
          tmr_d   = '0;
        end else if (hit) begin
          state_d = SEQ_OFF;
          latch_d = 1'b1;
        end
      end
      SEQ_STOP: begin
        if (tmr_q == STOP_END) state_d = SEQ_OFF;
        else                   tmr_d   = tmr_q + 1'b1;
      end
      default: state_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_OFF;
      tmr_q     <= '0;
      latch_q   <= 1'b0;
      req_db_d  <= 1'b1;
      rails_off <= 1'b1;
    end else begin
      state_q   <= state_d;
      tmr_q     <= tmr_d;
      latch_q   <= latch_d;
      req_db_d  <= req_db;
      rails_off <= (state_d == SEQ_OFF);
    end
  end

  assign fault_active = latch_q;

  // R7
  latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !req_rise) |=> latch_q);

  // R9
  fault_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_q) |-> !$past(req_db));

  // R4
  blank_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN && $past(state_q) != SEQ_RUN) |-> ($past(state_q) == SEQ_BLANK));

  // R7
  run_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !rails_off |-> !fault_active);

endmodule

// File: tb/sim_supply_fault_seq.sv
`timescale 1ns/1ps
module sim_supply_fault_seq;

  localparam int NR    = 3;
  localparam int DEB   = 8;
  localparam int BLK   = 20;
  localparam int FLT   = 4;
  localparam int OFD   = 5;
  localparam int L_ON  = DEB + 3;
  localparam int L_OFF = DEB + 3 + OFD;
  localparam int L_FLT = FLT + 3;

  logic          clk   = 1'b0;
  logic          rst   = 1'b1;
  logic          req_n = 1'b1;
  logic [NR-1:0] ov    = '0;
  logic [NR-1:0] uv    = '0;
  logic          rails_off;
  logic          fault_active;

  supply_fault_seq #(
    .NRAILS(NR), .DEB_CYC(DEB), .BLANK_CYC(BLK), .FILT_CYC(FLT), .OFFDLY_CYC(OFD)
  ) u0 (
    .clk(clk), .rst(rst), .onoff_req_n(req_n), .ov_flag(ov), .uv_flag(uv),
    .rails_off(rails_off), .fault_active(fault_active)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  po;
    logic  fa;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Driver side: schedule an expected output pair dly cycles from now.
  task automatic expect_at(input int dly, input logic po, input logic fa, input string tag);
    exp_t e;
    int   pos;
    e.due = cyc + dly;
    e.po  = po;
    e.fa  = fa;
    e.tag = tag;
    pos   = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].due > e.due) begin
        pos = i;
        break;
      end
    end
    sb.insert(pos, e);
  endtask

  // Monitor side: compare due items at the falling edge.
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      n_run++;
      if (e.due != cyc || rails_off !== e.po || fault_active !== e.fa) begin
        n_fail++;
        $display("FAIL %s: rails_off=%b fault_active=%b expected rails_off=%b fault_active=%b (cycle %0d, due %0d)",
                 e.tag, rails_off, fault_active, e.po, e.fa, cyc, e.due);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R1 reset state");
    drain();
    step(2);

    // R3: low glitch of DEB-1 cycles does not turn the rails on
    req_n = 1'b0;
    expect_at(L_ON - 1, 1'b1, 1'b0, "R3 short low request");
    expect_at(L_ON,     1'b1, 1'b0, "R3 short low request");
    expect_at(L_ON + 5, 1'b1, 1'b0, "R3 short low request");
    step(DEB - 1);
    req_n = 1'b1;
    drain();
    step(5);

    // R2: debounced turn-on latency
    req_n = 1'b0;
    expect_at(L_ON - 1, 1'b1, 1'b0, "R2 before debounce completes");
    expect_at(L_ON,     1'b0, 1'b0, "R2 rails on after debounce");
    drain();
    step(BLK + 5);

    // R3: high glitch while running is ignored
    req_n = 1'b1;
    expect_at(L_ON,     1'b0, 1'b0, "R3 short high request");
    expect_at(L_ON + 8, 1'b0, 1'b0, "R3 short high request");
    step(DEB - 1);
    req_n = 1'b0;
    drain();
    step(2);

    // R6: two 3-cycle pulses split by a 1-cycle gap never qualify
    ov[1] = 1'b1;
    expect_at(14, 1'b0, 1'b0, "R6 short pulses filtered");
    step(3);
    ov[1] = 1'b0;
    step(1);
    ov[1] = 1'b1;
    step(3);
    ov[1] = 1'b0;
    drain();
    step(2);

    // R10: undervoltage on rail 2 while running
    uv[2] = 1'b1;
    expect_at(L_FLT - 1, 1'b0, 1'b0, "R10 rail 2 before filter");
    expect_at(L_FLT,     1'b1, 1'b1, "R10 rail 2 undervoltage trips");
    drain();
    uv[2] = 1'b0;

    // R7: latch holds with request low, clears on rising request
    step(DEB + 10);
    expect_at(1, 1'b1, 1'b1, "R7 latch holds with request low");
    drain();
    req_n = 1'b1;
    expect_at(L_ON - 1, 1'b1, 1'b1, "R7 latch before debounced rise");
    expect_at(L_ON,     1'b1, 1'b0, "R7 latch cleared by rising request");
    drain();

    // R9: fault while off is ignored
    ov[0] = 1'b1;
    expect_at(20, 1'b1, 1'b0, "R9 overvoltage while off ignored");
    drain();
    ov[0] = 1'b0;
    step(3);

    // R4: undervoltage held from start of blanking
    req_n = 1'b0;
    expect_at(L_ON, 1'b0, 1'b0, "R2 second turn-on");
    step(L_ON);
    uv[0] = 1'b1;
    expect_at(BLK,           1'b0, 1'b0, "R4 undervoltage masked in blanking");
    expect_at(BLK + FLT,     1'b0, 1'b0, "R4 undervoltage filtered after blanking");
    expect_at(BLK + FLT + 1, 1'b1, 1'b1, "R4 undervoltage trips after blanking");
    drain();
    uv[0] = 1'b0;

    req_n = 1'b1;
    expect_at(L_ON, 1'b1, 1'b0, "R7 cleared before next turn-on");
    drain();
    step(2);

    // R5: overvoltage during blanking is not masked
    req_n = 1'b0;
    expect_at(L_ON, 1'b0, 1'b0, "R2 third turn-on");
    step(L_ON);
    ov[1] = 1'b1;
    expect_at(L_FLT - 1, 1'b0, 1'b0, "R5 overvoltage before filter");
    expect_at(L_FLT,     1'b1, 1'b1, "R5 overvoltage trips in blanking");
    drain();
    ov[1] = 1'b0;

    req_n = 1'b1;
    expect_at(L_ON, 1'b1, 1'b0, "R7 cleared before turn-off test");
    drain();
    step(2);
    req_n = 1'b0;
    expect_at(L_ON, 1'b0, 1'b0, "R2 fourth turn-on");
    drain();
    step(BLK + 5);

    // R8 turn-off delay; R9 fault during turn-off delay ignored
    req_n = 1'b1;
    expect_at(L_OFF - 1,  1'b0, 1'b0, "R8 rails still on during delay");
    expect_at(L_OFF,      1'b1, 1'b0, "R8 rails off after delay");
    expect_at(L_OFF + 10, 1'b1, 1'b0, "R9 undervoltage during turn-off ignored");
    step(DEB + 2);
    uv[1] = 1'b1;
    drain();
    uv[1] = 1'b0;
    step(2);

    done = 1'b1;
    report();
    $finish;
  end

endmodule